// File: doc/BRIEF.md
# Decoder Stage Dispatch Scheduler

This block sequences a six-stage video decode pipeline whose stages share a single execution resource. At any time exactly one stage is current. The scheduler launches that stage with a one-cycle start strobe and a stage number, then waits for the stage to answer with a done pulse. The done pulse carries a "produced output" flag, and a "stall" flag that only the inter-prediction stage uses. From that answer the scheduler picks the next stage. Depending on the stage, a productive attempt either pushes work forward or pulls control back toward an earlier stage. An unproductive attempt moves control the other way.

The stage datapaths live outside the block and act as simple responders. An end-of-stream input stops new launches. An attempt that is already in flight is still allowed to finish.

The scheduler has two phases. In `PH_IDLE` it is ready to launch. In `PH_WAIT` one attempt is outstanding. The transition `launch` (IDLE to WAIT) fires when end-of-stream is low. The transition `retire` (WAIT to IDLE) fires on an accepted done pulse. The current stage is one of `ST_UNWRAP`, `ST_PARSE`, `ST_IQIT`, `ST_INTER`, `ST_INTRA` or `ST_DEBLOCK`. It changes only on `retire`.

Top module: `stage_dispatch_sched`

## Requirements
- R1: After reset `start_o` is 0 and `stage_o` is 0. Stage codes are: unwrap=0, parse=1, inverse quantise/transform=2, inter=3, intra=4, deblock=5.
- R2: On an accepted done from unwrap (0), the next stage is parse (1) if `produced_i` is 1, and unwrap (0) otherwise.
- R3: On an accepted done from parse (1), the next stage is 2 if produced, and 0 otherwise.
- R4: On an accepted done from inverse quantise/transform (2), the next stage is 1 if produced, and 3 otherwise.
- R5: On an accepted done from inter (3), the next stage is 5 if `stall_i` is 1, whatever the produced flag says. Without a stall it is 2 if produced, and 4 otherwise.
- R6: On an accepted done from intra (4), the next stage is 3 if produced, and 5 otherwise.
- R7: On an accepted done from deblock (5), the next stage is always 4.
- R8: `start_o` is high for exactly one cycle per attempt, with `stage_o` giving the stage launched. It rises on the clock edge after reset release, or on the edge after the accepting done. At most one attempt is outstanding.
- R9: While `eos_i` is sampled high, no new start is issued. An outstanding attempt still retires on its done pulse.
- R10: A done pulse while no attempt is outstanding has no effect. The produced and stall flags have no effect without an accepted done. The stall flag has no effect from any stage other than inter.
- R11: `stage_o` holds its value for as long as an attempt is outstanding and unanswered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eos_i | input | 1 | End of stream; blocks new launches |
| done_i | input | 1 | Stage finished its attempt |
| produced_i | input | 1 | Attempt produced output (valid with done) |
| stall_i | input | 1 | Inter-prediction stall (valid with done) |
| start_o | output | 1 | One-cycle launch strobe |
| stage_o | output | 3 | Current / launched stage code |

## Verification
The bench uses the default build: six stages and a 3-bit stage code, so every stage and every transition arc is reachable. A responder answers each start after 0 to 3 cycles, which covers done in the same cycle that start is seen. It drives random produced and stall flags, so the stall override from inter is exercised alongside stall noise from the other stages. It also sends stray done pulses and flag noise while idle, and raises end-of-stream in bursts, both between attempts and during them. A behavioural model is compared against both outputs on every cycle.

// File: rtl/sds_pkg.sv
package sds_pkg;
    localparam int NUM_STAGES = 6;
    localparam int STAGE_W    = $clog2(NUM_STAGES);

    typedef enum logic [STAGE_W-1:0] {
        ST_UNWRAP  = 3'd0,
        ST_PARSE   = 3'd1,
        ST_IQIT    = 3'd2,
        ST_INTER   = 3'd3,
        ST_INTRA   = 3'd4,
        ST_DEBLOCK = 3'd5
    } stage_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_t;

    typedef struct packed {
        logic accept;
        logic produced;
        logic stall;
    } resp_t;
endpackage

// File: rtl/sds_resp_gate.sv
module sds_resp_gate
    import sds_pkg::*;
(
    input  logic   waiting,
    input  stage_t cur_stage,
    input  logic   done_i,
    input  logic   produced_i,
    input  logic   stall_i,
    output resp_t  resp
);
    // Flags only pass with an accepted done; otherwise they read as cleared.
    always_comb begin
        resp.accept   = done_i & waiting;
        resp.produced = resp.accept & produced_i;
        resp.stall    = resp.accept & stall_i & (cur_stage == ST_INTER);
    end
endmodule

// File: rtl/sds_next_stage.sv
module sds_next_stage
    import sds_pkg::*;
(
    input  stage_t cur_stage,
    input  resp_t  resp,
    output stage_t nxt_stage
);
    always_comb begin
        unique case (cur_stage)
            ST_UNWRAP:  nxt_stage = resp.produced ? ST_PARSE : ST_UNWRAP;
            ST_PARSE:   nxt_stage = resp.produced ? ST_IQIT  : ST_UNWRAP;
            ST_IQIT:    nxt_stage = resp.produced ? ST_PARSE : ST_INTER;
            ST_INTER: begin
                if (resp.stall)         nxt_stage = ST_DEBLOCK;
                else if (resp.produced) nxt_stage = ST_IQIT;
                else                    nxt_stage = ST_INTRA;
            end
            ST_INTRA:   nxt_stage = resp.produced ? ST_INTER : ST_DEBLOCK;
            ST_DEBLOCK: nxt_stage = ST_INTRA;
            default:    nxt_stage = ST_UNWRAP;
        endcase
    end
endmodule

// File: rtl/sds_phase_fsm.sv
module sds_phase_fsm
    import sds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eos_i,
    input  logic accept,
    output logic start_o,
    output logic waiting
);
    phase_t phase_q, phase_d;
    logic   start_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            start_o <= 1'b0;
        end else begin
            phase_q <= phase_d;
            start_o <= start_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        start_d = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (!eos_i) begin           // launch
                phase_d = PH_WAIT;
                start_d = 1'b1;
            end
            PH_WAIT: if (accept) phase_d = PH_IDLE; // retire
            default: phase_d = PH_IDLE;
        endcase
    end

    assign waiting = (phase_q == PH_WAIT);

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R8
    start_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> waiting);
    // R9
    eos_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_i |=> !start_o);
endmodule

// File: rtl/stage_dispatch_sched.sv
module stage_dispatch_sched
    import sds_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eos_i,
    input  logic               done_i,
    input  logic               produced_i,
    input  logic               stall_i,
    output logic               start_o,
    output logic [STAGE_W-1:0] stage_o
);
    stage_t cur_q, nxt;
    resp_t  resp;
    logic   waiting;

    sds_phase_fsm u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .eos_i   (eos_i),
        .accept  (resp.accept),
        .start_o (start_o),
        .waiting (waiting)
    );

    sds_resp_gate u_gate (
        .waiting    (waiting),
        .cur_stage  (cur_q),
        .done_i     (done_i),
        .produced_i (produced_i),
        .stall_i    (stall_i),
        .resp       (resp)
    );

    sds_next_stage u_next (
        .cur_stage (cur_q),
        .resp      (resp),
        .nxt_stage (nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)           cur_q <= ST_UNWRAP;
        else if (resp.accept) cur_q <= nxt;
    end

    assign stage_o = cur_q;

    // R11
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !done_i) |=> $stable(stage_o));
    // R7
    deblock_to_intra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && done_i && stage_o == ST_DEBLOCK) |=> stage_o == ST_INTRA);
    // R5
    inter_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && done_i && stall_i && stage_o == ST_INTER) |=> stage_o == ST_DEBLOCK);
    // R10
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting) |=> $stable(stage_o));
endmodule

// File: tb/sim_stage_dispatch_sched.sv
`timescale 1ns/1ps
module sim_stage_dispatch_sched;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eos_i = 1'b0, done_i = 1'b0, produced_i = 1'b0, stall_i = 1'b0;
    logic start_o;
    logic [2:0] stage_o;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    stage_dispatch_sched u0 (
        .clk(clk), .rst_n(rst_n), .eos_i(eos_i), .done_i(done_i),
        .produced_i(produced_i), .stall_i(stall_i),
        .start_o(start_o), .stage_o(stage_o)
    );

    // behavioural reference
    int    m_cur = 0;
    bit    m_wait = 0;
    bit    m_start = 0;
    string m_stage_tag = "R1";
    string m_start_tag = "R1";

    function automatic int follow(int s, bit p, bit st);
        if (s == 3 && st) return 5;   // R5 stall override
        if (s == 5) return 4;         // R7
        if (s == 0) return p ? 1 : 0; // R2
        if (s == 1) return p ? 2 : 0; // R3
        if (s == 2) return p ? 1 : 3; // R4
        if (s == 3) return p ? 2 : 4; // R5
        return p ? 3 : 5;             // R6
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 0; m_wait = 0; m_start = 0;
            m_stage_tag = "R1"; m_start_tag = "R1";
        end else if (!m_wait) begin
            m_stage_tag = done_i ? "R10" : "R8";
            m_start_tag = eos_i ? "R9" : "R8";
            m_start = !eos_i;
            m_wait  = !eos_i;
        end else begin
            m_start = 0;
            m_start_tag = "R8";
            if (done_i) begin
                m_stage_tag = (stall_i && m_cur != 3) ? "R10" : tag_of(m_cur);
                m_cur  = follow(m_cur, produced_i, stall_i);
                m_wait = 0;
            end else begin
                m_stage_tag = "R11";
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(m_start_tag, int'(start_o), int'(m_start));
            check(m_stage_tag, int'(stage_o), m_cur);
        end
    end

    int unsigned rs = 32'h1234_5678;
    function automatic int unsigned rnd();
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        return rs;
    endfunction

    initial begin
        int unsigned r;
        bit pend;
        int lat;
        pend = 0; lat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state, before the first active edge after release: R1
        check("R1", int'(start_o), 0);
        check("R1", int'(stage_o), 0);
        // hold eos during the first cycles: R9
        eos_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", int'(start_o), 0);
        eos_i = 1'b0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            r = rnd();
            if (start_o) begin pend = 1; lat = int'(r % 4); end
            if (r[31:28] == 4'hF) eos_i = ~eos_i;
            else if (eos_i && r[27:25] == 3'd0) eos_i = 1'b0;
            produced_i = r[8];
            stall_i    = (r[11:10] == 2'b00);
            if (pend) begin
                if (lat == 0) begin
                    done_i = 1'b1;
                    pend = 0;
                end else begin
                    done_i = 1'b0;
                    lat--;
                end
            end else begin
                done_i = (r[15:12] == 4'h0); // stray pulse: R10
            end
        end
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule